// File: doc/BRIEF.md
# USB Device Control and Status Register Bank

This block holds the processor-visible registers of a small full-speed USB device interface. A byte-wide register bus with a two-bit offset reaches three registers: a control register with power-down, force-suspend and force-reset bits, a seven-bit device address register, and a read-only status word. Register reads are combinational. A write takes effect at the clock edge on which `cpu_sel` and `cpu_wr` are both high.

The protocol engine reports three kinds of event as single-cycle pulses: bus activity, a received bus reset, and a completed transfer. A completed transfer carries its token PID, endpoint number and direction. Bus activity clears force-suspend. A bus reset, or a held force-reset, wipes the device address. A completed transfer updates the status word, so that firmware can find the endpoint that needs service and, for the control endpoint, which token arrived.

When software releases a forced reset, a USB-reset interrupt request is raised, provided the enable input is high. It stays pending until the processor pulses the acknowledge input.

Top module: `usb_csr_bank`

## Requirements
- R1: After reset, every offset reads 00h and `reg_off`, `suspend`, `if_reset` and `usbrst_irq` are all 0.
- R2: Offset 0 is the control register. Bit 2 is power-down, bit 1 is force-suspend and bit 0 is force-reset. Bits 7:3 read 0. `reg_off` equals bit 2 from the cycle after the write.
- R3: A write sets or clears force-suspend, which drives `suspend`. An `ev_activity` pulse clears it at the next edge, and it wins over a software write that sets the bit in the same cycle.
- R4: While force-reset is 1, `if_reset` is 1. From the following edge on, the device address reads 00h and writes to it are lost.
- R5: A control write that changes force-reset from 1 to 0 while `irq_enable` is high sets `usbrst_irq`. The request stays set until an `irq_ack` pulse clears it. A new request wins over an acknowledge in the same cycle. With `irq_enable` low, no request is raised.
- R6: Offset 1 is the device address. Bits 6:0 store the written value, and bit 7 always reads 0.
- R7: An `ev_bus_reset` pulse clears the device address to 00h, even when a write to offset 1 happens in the same cycle.
- R8: Offset 2 is the status word and is read-only: writes to it have no effect. Offset 3 always reads 00h.
- R9: A transfer-complete event on endpoint 0 stores PID bits 3:2 in status bits 7:6 and 00 in bits 4:3, and leaves bit 5 unchanged. SETUP (1101) gives 11, OUT (0001) gives 00 and IN (1001) gives 10.
- R10: A transfer-complete event on endpoint 1 or 2 stores the direction in status bit 5 (1 for IN, 0 for OUT) and the endpoint number in bits 4:3, and leaves bits 7:6 unchanged.
- R11: A transfer-complete event naming endpoint 3 leaves the status word unchanged. Status bits 2:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | Register access strobe |
| cpu_wr | input | 1 | Write when high, read when low |
| cpu_addr | input | 2 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational) |
| ev_activity | input | 1 | Bus activity pulse |
| ev_bus_reset | input | 1 | Bus reset received pulse |
| ev_xfer_done | input | 1 | Transfer complete pulse |
| ev_pid | input | 4 | Token PID of the completed transfer |
| ev_ep | input | 2 | Endpoint number of the completed transfer |
| ev_dir_in | input | 1 | Direction, 1 for IN |
| irq_enable | input | 1 | USB-reset interrupt enable |
| irq_ack | input | 1 | Single-cycle interrupt acknowledge |
| reg_off | output | 1 | Regulator off |
| suspend | output | 1 | Suspend request |
| if_reset | output | 1 | Interface held in reset |
| usbrst_irq | output | 1 | USB-reset interrupt pending |

## Verification
The assertions assume that the event inputs are clean single-cycle pulses, sampled at the same edge as the bus, and that `ev_pid`, `ev_ep` and `ev_dir_in` are valid whenever `ev_xfer_done` is high. They also assume that `irq_enable` is steady across the cycle in which force-reset is released. The stimulus drives every input on the falling edge and returns the pulses to zero one cycle later. It sweeps all 256 control and address values, and all 128 combinations of endpoint, PID and direction, including the unused endpoint value 3. It collides activity, bus reset and acknowledge with register writes only in the cases that R3, R5 and R7 name.

// File: rtl/usb_csr_pkg.sv
package usb_csr_pkg;
    localparam int BUS_DW  = 8;
    localparam int BUS_AW  = 2;
    localparam int DEV_AW  = 7;
    localparam int EP_W    = 2;
    localparam int NUM_EP  = 3;
    localparam int CTRL_W  = 3;

    localparam logic [BUS_AW-1:0] OFS_CTRL = 2'd0;
    localparam logic [BUS_AW-1:0] OFS_ADDR = 2'd1;
    localparam logic [BUS_AW-1:0] OFS_STAT = 2'd2;

    typedef struct packed {
        logic pdwn;
        logic susp;
        logic frc;
        logic pend;
    } ctrl_state_t;

    typedef struct packed {
        logic [1:0]      pid_hi;
        logic            dir_in;
        logic [EP_W-1:0] ep;
    } stat_state_t;
endpackage

// File: rtl/csr_ctrl_reg.sv
module csr_ctrl_reg
    import usb_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              activity,
    input  logic              irq_enable,
    input  logic              irq_ack,
    output logic [CTRL_W-1:0] ctrl_bits,
    output logic              irq_pend
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.pdwn = wdata[2];
            st_d.susp = wdata[1];
            st_d.frc  = wdata[0];
        end
        // hardware activity beats software set of suspend
        if (activity) st_d.susp = 1'b0;
        if (irq_ack)  st_d.pend = 1'b0;
        // release of forced reset raises the request; wins over ack
        if (st_q.frc && !st_d.frc && irq_enable) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_bits = {st_q.pdwn, st_q.susp, st_q.frc};
    assign irq_pend  = st_q.pend;
endmodule

// File: rtl/csr_addr_reg.sv
module csr_addr_reg
    import usb_csr_pkg::*;
#(
    parameter int AW = DEV_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wdata,
    input  logic          clear,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (wr_en) addr_d = wdata;
        if (clear) addr_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;
endmodule

// File: rtl/csr_status_reg.sv
module csr_status_reg
    import usb_csr_pkg::*;
#(
    parameter int EPS = NUM_EP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xfer_done,
    input  logic [1:0]      pid_hi,
    input  logic [EP_W-1:0] ep,
    input  logic            dir_in,
    output logic [BUS_DW-1:0] stat
);
    localparam int PAD_W = BUS_DW - $bits(stat_state_t);

    stat_state_t st_d, st_q;
    logic        ep_ok;

    assign ep_ok = (int'(ep) < EPS);

    always_comb begin
        st_d = st_q;
        if (xfer_done && ep_ok) begin
            st_d.ep = ep;
            if (ep == '0) st_d.pid_hi = pid_hi;
            else          st_d.dir_in = dir_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = {st_q, {PAD_W{1'b0}}};
endmodule

// File: rtl/usb_csr_bank.sv
module usb_csr_bank
    import usb_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [BUS_AW-1:0] cpu_addr,
    input  logic [BUS_DW-1:0] cpu_wdata,
    output logic [BUS_DW-1:0] cpu_rdata,
    input  logic              ev_activity,
    input  logic              ev_bus_reset,
    input  logic              ev_xfer_done,
    input  logic [3:0]        ev_pid,
    input  logic [EP_W-1:0]   ev_ep,
    input  logic              ev_dir_in,
    input  logic              irq_enable,
    input  logic              irq_ack,
    output logic              reg_off,
    output logic              suspend,
    output logic              if_reset,
    output logic              usbrst_irq
);
    logic              wr_ctrl, wr_addr;
    logic [CTRL_W-1:0] ctrl_bits;
    logic [DEV_AW-1:0] dev_addr;
    logic [BUS_DW-1:0] stat_word;

    assign wr_ctrl = cpu_sel && cpu_wr && (cpu_addr == OFS_CTRL);
    assign wr_addr = cpu_sel && cpu_wr && (cpu_addr == OFS_ADDR);

    csr_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_ctrl),
        .wdata      (cpu_wdata[CTRL_W-1:0]),
        .activity   (ev_activity),
        .irq_enable (irq_enable),
        .irq_ack    (irq_ack),
        .ctrl_bits  (ctrl_bits),
        .irq_pend   (usbrst_irq)
    );

    csr_addr_reg #(.AW(DEV_AW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_addr),
        .wdata (cpu_wdata[DEV_AW-1:0]),
        .clear (ev_bus_reset || ctrl_bits[0]),
        .addr  (dev_addr)
    );

    csr_status_reg #(.EPS(NUM_EP)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_done (ev_xfer_done),
        .pid_hi    (ev_pid[3:2]),
        .ep        (ev_ep),
        .dir_in    (ev_dir_in),
        .stat      (stat_word)
    );

    always_comb begin
        unique case (cpu_addr)
            OFS_CTRL: cpu_rdata = {{(BUS_DW-CTRL_W){1'b0}}, ctrl_bits};
            OFS_ADDR: cpu_rdata = {{(BUS_DW-DEV_AW){1'b0}}, dev_addr};
            OFS_STAT: cpu_rdata = stat_word;
            default:  cpu_rdata = '0;
        endcase
    end

    assign reg_off  = ctrl_bits[2];
    assign suspend  = ctrl_bits[1];
    assign if_reset = ctrl_bits[0];
endmodule

// File: rtl/usb_csr_checker.sv
module usb_csr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_sel,
    input logic       cpu_wr,
    input logic [1:0] cpu_addr,
    input logic [7:0] cpu_wdata,
    input logic [7:0] cpu_rdata,
    input logic       ev_activity,
    input logic       ev_bus_reset,
    input logic       ev_xfer_done,
    input logic [3:0] ev_pid,
    input logic [1:0] ev_ep,
    input logic       ev_dir_in,
    input logic       irq_enable,
    input logic       irq_ack,
    input logic       reg_off,
    input logic       suspend,
    input logic       if_reset,
    input logic       usbrst_irq,
    input logic [6:0] dev_addr,
    input logic [7:0] stat_word
);
    p_regoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_wr && cpu_addr == 2'd0) |=> (reg_off == $past(cpu_wdata[2])));

    p_susp_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_activity |=> !suspend);

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        if_reset |=> (dev_addr == 7'd0));

    p_irq_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(if_reset) && $past(irq_enable)) |-> usbrst_irq);

    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (usbrst_irq && !irq_ack) |=> usbrst_irq);

    p_busrst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bus_reset |=> (dev_addr == 7'd0));

    p_ep_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_xfer_done && ev_ep != 2'd3) |=> (stat_word[4:3] == $past(ev_ep)));

    p_ep_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_xfer_done && ev_ep == 2'd3) |=> $stable(stat_word));

    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == 2'd2) |-> (cpu_rdata[2:0] == 3'd0));
endmodule

bind usb_csr_bank usb_csr_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_sel      (cpu_sel),
    .cpu_wr       (cpu_wr),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .ev_activity  (ev_activity),
    .ev_bus_reset (ev_bus_reset),
    .ev_xfer_done (ev_xfer_done),
    .ev_pid       (ev_pid),
    .ev_ep        (ev_ep),
    .ev_dir_in    (ev_dir_in),
    .irq_enable   (irq_enable),
    .irq_ack      (irq_ack),
    .reg_off      (reg_off),
    .suspend      (suspend),
    .if_reset     (if_reset),
    .usbrst_irq   (usbrst_irq),
    .dev_addr     (dev_addr),
    .stat_word    (stat_word)
);

// File: tb/sim_usb_csr_bank.sv
`timescale 1ns/1ps
module sim_usb_csr_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_sel = 1'b0, cpu_wr = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       ev_activity = 1'b0, ev_bus_reset = 1'b0, ev_xfer_done = 1'b0;
    logic [3:0] ev_pid = 4'd0;
    logic [1:0] ev_ep = 2'd0;
    logic       ev_dir_in = 1'b0;
    logic       irq_enable = 1'b0, irq_ack = 1'b0;
    logic       reg_off, suspend, if_reset, usbrst_irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] rd;

    always #4 clk = ~clk;

    usb_csr_bank u0 (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ev_activity(ev_activity), .ev_bus_reset(ev_bus_reset),
        .ev_xfer_done(ev_xfer_done), .ev_pid(ev_pid), .ev_ep(ev_ep),
        .ev_dir_in(ev_dir_in), .irq_enable(irq_enable), .irq_ack(irq_ack),
        .reg_off(reg_off), .suspend(suspend), .if_reset(if_reset),
        .usbrst_irq(usbrst_irq)
    );

    task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one bus cycle driven at the falling edge; pulses drop at the next falling edge
    task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d,
                       input logic act, input logic brst, input logic ack);
        @(negedge clk);
        cpu_sel = w; cpu_wr = w; cpu_addr = a; cpu_wdata = d;
        ev_activity = act; ev_bus_reset = brst; irq_ack = ack;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
        ev_activity = 1'b0; ev_bus_reset = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic xfer(input logic [3:0] pid, input logic [1:0] ep, input logic din);
        @(negedge clk);
        ev_xfer_done = 1'b1; ev_pid = pid; ev_ep = ep; ev_dir_in = din;
        @(negedge clk);
        ev_xfer_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [1:0] e_pid;
        logic       e_dir;
        logic [1:0] e_ep;
        logic [7:0] e_stat;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rdreg(a[1:0], rd);
            check(rd == 8'h00, "R1 reset read", rd, 8'h00);
        end
        check({reg_off, suspend, if_reset, usbrst_irq} == 4'b0, "R1 outputs",
              {4'b0, reg_off, suspend, if_reset, usbrst_irq}, 8'h00);

        // R2: control sweep, enable low so no request appears
        for (int v = 0; v < 256; v++) begin
            wr(2'd0, v[7:0]);
            rdreg(2'd0, rd);
            check(rd == (v[7:0] & 8'h07), "R2 ctrl readback", rd, v[7:0] & 8'h07);
            check({reg_off, suspend, if_reset} == v[2:0], "R2 ctrl outputs",
                  {5'b0, reg_off, suspend, if_reset}, {5'b0, v[2:0]});
            check(!usbrst_irq, "R5 no request when disabled", {7'b0, usbrst_irq}, 8'h00);
        end
        wr(2'd0, 8'h00);

        // R6: address sweep
        for (int v = 0; v < 256; v++) begin
            wr(2'd1, v[7:0]);
            rdreg(2'd1, rd);
            check(rd == (v[7:0] & 8'h7F), "R6 address readback", rd, v[7:0] & 8'h7F);
        end

        // R3: suspend set, cleared by activity, activity wins over a set
        wr(2'd0, 8'h02);
        check(suspend == 1'b1, "R3 suspend set", {7'b0, suspend}, 8'h01);
        cyc(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 1'b0);
        rdreg(2'd0, rd);
        check(rd == 8'h00 && !suspend, "R3 activity clears", rd, 8'h00);
        cyc(1'b1, 2'd0, 8'h06, 1'b1, 1'b0, 1'b0);
        rdreg(2'd0, rd);
        check(rd == 8'h04, "R3 activity beats set", rd, 8'h04);
        wr(2'd0, 8'h00);

        // R4: force reset wipes and holds the address
        wr(2'd1, 8'h55);
        wr(2'd0, 8'h01);
        check(if_reset == 1'b1, "R4 if_reset", {7'b0, if_reset}, 8'h01);
        @(negedge clk);
        rdreg(2'd1, rd);
        check(rd == 8'h00, "R4 address cleared", rd, 8'h00);
        wr(2'd1, 8'h22);
        rdreg(2'd1, rd);
        check(rd == 8'h00, "R4 address write ignored", rd, 8'h00);

        // R5: release raises request, ack clears, set wins over ack
        irq_enable = 1'b1;
        wr(2'd0, 8'h00);
        check(usbrst_irq == 1'b1, "R5 request raised", {7'b0, usbrst_irq}, 8'h01);
        repeat (3) @(negedge clk);
        check(usbrst_irq == 1'b1, "R5 request held", {7'b0, usbrst_irq}, 8'h01);
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
        check(usbrst_irq == 1'b0, "R5 ack clears", {7'b0, usbrst_irq}, 8'h00);
        wr(2'd0, 8'h01);
        cyc(1'b1, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
        check(usbrst_irq == 1'b1, "R5 set beats ack", {7'b0, usbrst_irq}, 8'h01);
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 1'b1);
        irq_enable = 1'b0;
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h00);
        check(usbrst_irq == 1'b0, "R5 disabled release", {7'b0, usbrst_irq}, 8'h00);

        // R7: bus reset clears address, beats a same-cycle write
        wr(2'd1, 8'h33);
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 1'b0);
        rdreg(2'd1, rd);
        check(rd == 8'h00, "R7 bus reset clears", rd, 8'h00);
        cyc(1'b1, 2'd1, 8'h44, 1'b0, 1'b1, 1'b0);
        rdreg(2'd1, rd);
        check(rd == 8'h00, "R7 bus reset beats write", rd, 8'h00);

        // R8: status read-only, offset 3 reads zero
        wr(2'd2, 8'hFF);
        rdreg(2'd2, rd);
        check(rd == 8'h00, "R8 status write ignored", rd, 8'h00);
        wr(2'd3, 8'hFF);
        rdreg(2'd3, rd);
        check(rd == 8'h00, "R8 offset 3 zero", rd, 8'h00);

        // R9 R10 R11: event sweep over endpoint, PID and direction
        e_pid = 2'b00; e_dir = 1'b0; e_ep = 2'b00;
        for (int ep = 0; ep < 4; ep++) begin
            for (int pid = 0; pid < 16; pid++) begin
                for (int d = 0; d < 2; d++) begin
                    xfer(pid[3:0], ep[1:0], d[0]);
                    if (ep == 0) begin
                        e_pid = pid[3:2]; e_ep = 2'd0;
                    end else if (ep < 3) begin
                        e_dir = d[0]; e_ep = ep[1:0];
                    end
                    e_stat = {e_pid, e_dir, e_ep, 3'b000};
                    rdreg(2'd2, rd);
                    if (ep == 0)      check(rd == e_stat, "R9 ep0 capture", rd, e_stat);
                    else if (ep < 3)  check(rd == e_stat, "R10 ep1/2 capture", rd, e_stat);
                    else              check(rd == e_stat, "R11 ep3 ignored", rd, e_stat);
                end
            end
        end

        // R9: named tokens on endpoint 0
        xfer(4'b1101, 2'd0, 1'b0);
        rdreg(2'd2, rd);
        check(rd[7:6] == 2'b11, "R9 SETUP", {6'b0, rd[7:6]}, 8'h03);
        xfer(4'b0001, 2'd0, 1'b0);
        rdreg(2'd2, rd);
        check(rd[7:6] == 2'b00, "R9 OUT", {6'b0, rd[7:6]}, 8'h00);
        xfer(4'b1001, 2'd0, 1'b0);
        rdreg(2'd2, rd);
        check(rd[7:6] == 2'b10, "R9 IN", {6'b0, rd[7:6]}, 8'h02);

        finish_run();
    end
endmodule